// File: doc/BRIEF.md
# Gated-Operand ALU with Output Shifter

This block is the arithmetic stage of a microcoded datapath. One operand comes from a holding register and the other from a bus. An 8-bit control byte decides three things: whether each operand is used or replaced by zero, whether the first operand is inverted, and whether a carry of one enters the adder. The same byte also picks one of four functions and an optional shift of the result. Constants such as 0, 1 and -1, and operations such as B+1 and B-1, come from combining these bits. No opcode is dedicated to them.

The shifted result is registered, together with a negative flag and a zero flag. Both flags are taken from the ALU output before the shift. All three outputs change on the rising clock edge that follows the cycle in which the operands and control byte are presented. This gives one cycle of latency. A synchronous active-high reset clears all three outputs.

Top module: `gated_alu_shift`

## Requirements
- R1: The control byte, from bit 7 down to bit 0, is: left-shift-by-8 select, arithmetic-right-shift select, function bit high, function bit low, A enable, B enable, A invert, carry-in.
- R2: When the A enable is 0, the A operand is zero before any inversion. When the B enable is 0, the B operand is zero. For example, 0x10 yields 0 and 0x31 yields 1.
- R3: When the A-invert bit is 1, the gated A operand is inverted. For example, control 0x36 yields B-1 and control 0x32 yields -1.
- R4: The function bits {bit 5, bit 4} select the operation: 00 is A AND B, 01 is A OR B, 10 is NOT B, and 11 is A + B + carry-in, taken modulo 2^32.
- R5: The carry-in bit adds one only in the add function. It has no effect on the AND, OR and NOT B functions.
- R6: When both shift selects are 0, the ALU output is passed through unshifted.
- R7: When bit 7 is 1, the ALU output is shifted left by 8 bits and the low bits are filled with zeros.
- R8: When bit 6 is 1 and bit 7 is 0, the ALU output is shifted right by 1 bit and the sign bit is kept.
- R9: When both shift selects are 1, only the left shift by 8 is applied.
- R10: The negative flag equals bit 31 of the unshifted ALU output. The zero flag is 1 exactly when all 32 bits of the unshifted ALU output are zero.
- R11: The result and flag outputs are registered. They reflect the inputs from the previous clock edge. A synchronous reset clears all three outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl | input | 8 | Control byte (layout in R1) |
| a_in | input | 32 | Operand from the holding register |
| b_in | input | 32 | Operand from the bus |
| res_q | output | 32 | Registered shifted result |
| neg_q | output | 1 | Registered negative flag of the unshifted result |
| zero_q | output | 1 | Registered zero flag of the unshifted result |

## Verification
The assertions assume that the operands and control byte hold steady through each active clock edge and are free of X. They judge the result only from inputs that were sampled while reset was low. The bench drives inputs only on the falling edge and keeps every value defined. It returns to the falling edge before it compares any output. It covers the control bytes that the interpreter uses, then every one of the 256 control values with operands that include zero, all ones and sign-boundary values.

// File: rtl/alu_pkg.sv
package alu_pkg;
  // Packed so that the first member is bit 7 of the control byte.
  typedef struct packed {
    logic sll8;
    logic sra1;
    logic fn_hi;
    logic fn_lo;
    logic ena;
    logic enb;
    logic inva;
    logic cin;
  } alu_ctrl_t;

  typedef enum logic [1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_ADD  = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/alu_operand_gate.sv
module alu_operand_gate #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_raw,
  input  logic [W-1:0] b_raw,
  input  logic         ena,
  input  logic         enb,
  input  logic         inva,
  output logic [W-1:0] a_op,
  output logic [W-1:0] b_op
);
  logic [W-1:0] a_gated;

  always_comb begin
    a_gated = ena ? a_raw : '0;
    a_op    = inva ? ~a_gated : a_gated;
    b_op    = enb ? b_raw : '0;
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_op,
  input  logic [W-1:0] b_op,
  input  alu_fn_e      fn,
  input  logic         cin,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (fn)
      FN_AND:  y = a_op & b_op;
      FN_OR:   y = a_op | b_op;
      FN_NOTB: y = ~b_op;
      default: y = a_op + b_op + {{(W-1){1'b0}}, cin};
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int W      = 32,
  parameter int LSHIFT = 8
) (
  input  logic [W-1:0] d,
  input  logic         sll,
  input  logic         sra,
  output logic [W-1:0] q
);
  always_comb begin
    if (sll)      q = d << LSHIFT;
    else if (sra) q = {d[W-1], d[W-1:1]};
    else          q = d;
  end
endmodule

// File: rtl/gated_alu_shift.sv
module gated_alu_shift
  import alu_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int LSHIFT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       ctrl,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] res_q,
  output logic             neg_q,
  output logic             zero_q
);
  alu_ctrl_t        c;
  logic [WIDTH-1:0] a_op, b_op, alu_y, shifted;

  assign c = alu_ctrl_t'(ctrl);

  alu_operand_gate #(.W(WIDTH)) u_gate (
    .a_raw(a_in), .b_raw(b_in), .ena(c.ena), .enb(c.enb), .inva(c.inva),
    .a_op(a_op), .b_op(b_op)
  );

  alu_core #(.W(WIDTH)) u_core (
    .a_op(a_op), .b_op(b_op), .fn(alu_fn_e'({c.fn_hi, c.fn_lo})),
    .cin(c.cin), .y(alu_y)
  );

  alu_shifter #(.W(WIDTH), .LSHIFT(LSHIFT)) u_shift (
    .d(alu_y), .sll(c.sll8), .sra(c.sra1), .q(shifted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      neg_q  <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      res_q  <= shifted;
      neg_q  <= alu_y[WIDTH-1];
      zero_q <= (alu_y == '0);
    end
  end
endmodule

// File: rtl/gated_alu_shift_chk.sv
module gated_alu_shift_chk #(
  parameter int WIDTH  = 32,
  parameter int LSHIFT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       ctrl,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] res_q,
  input logic             neg_q,
  input logic             zero_q
);
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (res_q == '0 && !neg_q && !zero_q));

  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    zero_q |-> !neg_q);

  // R7
  sll_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl[7])) |-> (res_q[LSHIFT-1:0] == '0));

  // R8
  sra_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl[7:6]) == 2'b01) |-> (res_q[WIDTH-1] == res_q[WIDTH-2]));

  // R2
  const_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl) == 8'h10) |-> (res_q == '0 && zero_q));

  // R6
  pass_b_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctrl) == 8'h14) |-> (res_q == $past(b_in)));
endmodule

bind gated_alu_shift gated_alu_shift_chk #(.WIDTH(WIDTH), .LSHIFT(LSHIFT)) u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl), .a_in(a_in), .b_in(b_in),
  .res_q(res_q), .neg_q(neg_q), .zero_q(zero_q)
);

// File: tb/gated_alu_shift_test.sv
module gated_alu_shift_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  ctrl = 8'h00;
  logic [31:0] a_in = '0, b_in = '0;
  logic [31:0] res_q;
  logic        neg_q, zero_q;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  gated_alu_shift uut (
    .clk(clk), .rst(rst), .ctrl(ctrl), .a_in(a_in), .b_in(b_in),
    .res_q(res_q), .neg_q(neg_q), .zero_q(zero_q)
  );

  // Behavioural reference written from the requirements.
  function automatic logic [31:0] ref_unshifted(logic [7:0] c, logic [31:0] a, logic [31:0] b);
    longint unsigned av, bv, sum;
    av = c[3] ? a : 0;             // R2
    if (c[1]) av = ~av & 64'hFFFF_FFFF; // R3
    bv = c[2] ? b : 0;
    case (c[5:4])                  // R4
      2'd0: return av & bv;
      2'd1: return av | bv;
      2'd2: return ~bv;
      default: begin
        sum = av + bv + c[0];      // R5
        return sum[31:0];
      end
    endcase
  endfunction

  function automatic logic [31:0] ref_shift(logic [7:0] c, logic [31:0] y);
    if (c[7]) return y << 8;                       // R7, R9
    if (c[6]) return $signed(y) >>> 1;             // R8
    return y;                                      // R6
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic run_op(string tag, logic [7:0] c, logic [31:0] a, logic [31:0] b);
    logic [31:0] y;
    @(negedge clk);
    ctrl = c; a_in = a; b_in = b;
    y = ref_unshifted(c, a, b);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " result"}, res_q, ref_shift(c, y));
    chk("R10 neg", {31'b0, neg_q}, {31'b0, y[31]});
    chk("R10 zero", {31'b0, zero_q}, {31'b0, (y == 0)});
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    pats = '{32'h0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h1234_5678, 32'h0000_0001};
    ctrl = 8'hFF; a_in = 32'hFFFF_FFFF; b_in = 32'h1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset res", res_q, 32'h0);
    chk("R11 reset flags", {30'b0, neg_q, zero_q}, 32'h0);
    rst = 1'b0;

    run_op("R6 pass B inc ignored R5", 8'h15, 32'hDEAD_BEEF, 32'h0000_00FF);
    run_op("R4 B plus 1", 8'h35, 32'h5555_5555, 32'hFFFF_FFFF);
    run_op("R3 B minus 1", 8'h36, 32'h1, 32'h0);
    run_op("R3 minus one", 8'h32, 32'h1234, 32'h5678);
    run_op("R2 const zero", 8'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R2 const one", 8'h31, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op("R4 A plus B", 8'h3C, 32'h7FFF_FFFF, 32'h1);
    run_op("R4 A and B", 8'h0C, 32'hF0F0_F0F0, 32'hFF00_FF00);
    run_op("R4 not B", 8'h24, 32'h0, 32'h0F0F_0000);
    run_op("R5 and inc ignored", 8'h0D, 32'hFFFF_FFFF, 32'h0);
    run_op("R7 sll8", 8'h94, 32'h0, 32'h8123_4567);
    run_op("R8 sra1 neg", 8'h54, 32'h0, 32'h8000_0002);
    run_op("R8 sra1 pos", 8'h54, 32'h0, 32'h7FFF_FFFE);
    run_op("R9 both shifts", 8'hD4, 32'h0, 32'h00AB_CDEF);
    run_op("R10 sll hides sign", 8'h94, 32'h0, 32'h0100_0000);

    for (int c = 0; c < 256; c++)
      for (int k = 0; k < 6; k++)
        run_op("R1 sweep", 8'(c), pats[k], pats[(k + c) % 6]);

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R11 reset again", {res_q[31:2], neg_q, zero_q}, 32'h0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule